// File: doc/BRIEF.md
# Word-Interleaving Stereo Serial Audio Merger

This block joins several stereo serial audio sources into one faster stereo stream in the standard I2S format. Each source sends 16-bit left and right words per frame. The merged stream has the same frame rate but carries every source's words back to back in one frame, so a host that accepts only one stereo port can receive all the channels. The host then sorts the words back into channels in software.

The block runs on a single master clock and produces every serial clock from it. For the sources it drives a bit clock at one eighth of the master rate and a word select that flips every 16 of those bit clocks. For the merged stream it drives a bit clock at one quarter of the master rate and a matching word select. At the default settings a 12.288 MHz master clock gives 48 kHz frames, a 1.536 MHz source bit clock and a 3.072 MHz merged bit clock. Because all clocks come from one counter, the sources and the merged stream stay phase locked.

Each incoming word is held in a register until its slot in the merged frame comes up. The words of one source frame go out in the next merged frame. `WORD_W` and `NUM_IN` must be powers of two, and `NUM_IN` must be at least 2.

Top module: `i2s_word_merger`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, every output is 0.
- R2: `src_bclk` has a period of 8 master cycles: low for 4, then high for 4. Counting master edges since reset was released as k, it is high when k mod 8 is 4 or more.
- R3: `src_ws` is low for 128 master cycles (the left word) and high for 128 (the right word). It is high when k mod 256 is 128 or more, and it changes only while `src_bclk` is low.
- R4: `src_sd[s]` is sampled when `src_bclk` rises. A word arrives MSB first, starting one source bit clock after the `src_ws` edge that opens its half frame. So the right word's LSB arrives in the first bit period of the next frame.
- R5: `mrg_bclk`, `mrg_ws` and `mrg_sd` stay 0 until one complete source frame (left and right words) has been captured. They start when k = 260.
- R6: Once started, `mrg_bclk` has a period of 4 master cycles and is high when k mod 4 is 2 or more. `mrg_ws` equals `src_ws`, so it is low for 32 merged bit clocks and then high for 32.
- R7: `mrg_sd` changes only on the master edge where `mrg_bclk` falls. It is steady while `mrg_bclk` is high.
- R8: A merged frame holds four 16-bit slots in this order: source 0 left, source 1 left, source 0 right, source 1 right. Each slot is sent MSB first. The first slot's MSB comes one merged bit clock after `mrg_ws` falls, and the last slot's LSB falls in the first bit period of the following frame.
- R9: The words received in source frame n appear in merged frame n. Merged frame 0 is the first merged frame after start, and its last bit is presented when k = 514.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock (12.288 MHz in the intended use) |
| rst_n | input | 1 | Active-low synchronous reset |
| src_sd | input | NUM_IN | Serial data from each source, bit s for source s |
| src_bclk | output | 1 | Bit clock driven to the sources (master / 8) |
| src_ws | output | 1 | Word select driven to the sources, low = left |
| mrg_bclk | output | 1 | Bit clock of the merged stream (master / 4) |
| mrg_ws | output | 1 | Word select of the merged stream |
| mrg_sd | output | 1 | Serial data of the merged stream |

## Verification
The hardest case to reach is the window where a holding register is overwritten. A left word is replaced on the same master edge on which the merged stream moves from the second left slot into the first right slot. A right word is replaced only four master cycles after its last merged bit has left. These edges are only reached if real sources run frame after frame, so the bench acts as a bit-accurate transmitter that follows the block's own clocks. It sends a fresh set of words in every frame, including patterns with only the MSB set, only the LSB set, all ones and all zeros. A receiver in the bench rebuilds each merged frame and checks it against the words sent one frame earlier, so any word swapped or corrupted at a boundary shows up.

// File: rtl/i2s_merge_pkg.sv
package i2s_merge_pkg;

    // Channel of a stereo pair, as carried by a word select line.
    typedef enum logic {
        CH_LEFT  = 1'b0,
        CH_RIGHT = 1'b1
    } chan_e;

    // Bit index inside a word of a given width, MSB sent first.
    function automatic int unsigned msb_first_index(input int unsigned width,
                                                    input int unsigned pos);
        return width - 1 - pos;
    endfunction

endpackage

// File: rtl/i2s_merge_timebase.sv
// Frame counter shared by the source side and the merged side.
module i2s_merge_timebase #(
    parameter int ODIV_LOG2 = 2,
    parameter int IDIV_LOG2 = 3,
    parameter int IBIT_W    = 5,
    parameter int OBIT_W    = 6,
    parameter int CNT_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              sample_stb,
    output logic [IBIT_W-1:0] in_bit_idx,
    output logic              in_bclk,
    output logic              in_ws,
    output logic [OBIT_W-1:0] nxt_pos,
    output logic              nxt_edge,
    output logic              nxt_obclk,
    output logic              nxt_ws
);

    localparam logic [IDIV_LOG2-1:0] SAMPLE_PH =
        IDIV_LOG2'((1 << (IDIV_LOG2 - 1)) - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tb_state_t;

    tb_state_t st_q, st_d;

    always_comb begin
        st_d     = st_q;
        st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // The source side is seen from the registered count.
    assign sample_stb = (st_q.cnt[IDIV_LOG2-1:0] == SAMPLE_PH);
    assign in_bit_idx = st_q.cnt[CNT_W-1:IDIV_LOG2];
    assign in_bclk    = st_q.cnt[IDIV_LOG2-1];
    assign in_ws      = st_q.cnt[CNT_W-1];

    // The merged side is registered in the top, so it looks at the next count.
    assign nxt_pos   = st_d.cnt[CNT_W-1:ODIV_LOG2];
    assign nxt_edge  = (st_d.cnt[ODIV_LOG2-1:0] == '0);
    assign nxt_obclk = st_d.cnt[ODIV_LOG2-1];
    assign nxt_ws    = st_d.cnt[CNT_W-1];

endmodule

// File: rtl/i2s_merge_capture.sv
// Deserialiser for one stereo source plus its left and right holding words.
module i2s_merge_capture #(
    parameter int WORD_W = 16,
    parameter int IBIT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_stb,
    input  logic [IBIT_W-1:0] bit_idx,
    input  logic              sd,
    output logic [WORD_W-1:0] left_word,
    output logic [WORD_W-1:0] right_word
);

    // The left LSB lands in the first bit of the right half; the right LSB
    // lands in bit 0 of the following frame.
    localparam logic [IBIT_W-1:0] LEFT_DONE  = IBIT_W'(WORD_W);
    localparam logic [IBIT_W-1:0] RIGHT_DONE = '0;

    typedef struct packed {
        logic [WORD_W-1:0] shreg;
        logic [WORD_W-1:0] left;
        logic [WORD_W-1:0] right;
    } cap_state_t;

    cap_state_t st_q, st_d;
    logic [WORD_W-1:0] shifted;

    always_comb begin
        st_d    = st_q;
        shifted = {st_q.shreg[WORD_W-2:0], sd};
        if (sample_stb) begin
            st_d.shreg = shifted;
            if (bit_idx == LEFT_DONE) begin
                st_d.left = shifted;
            end
            if (bit_idx == RIGHT_DONE) begin
                st_d.right = shifted;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign left_word  = st_q.left;
    assign right_word = st_q.right;

endmodule

// File: rtl/i2s_merge_slot_mux.sv
// Picks the merged-stream bit for a bit position within the merged frame.
module i2s_merge_slot_mux
    import i2s_merge_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int NUM_IN = 2,
    parameter int OBIT_W = 6
) (
    input  logic [OBIT_W-1:0]              out_pos,
    input  logic [NUM_IN-1:0][WORD_W-1:0]  left_words,
    input  logic [NUM_IN-1:0][WORD_W-1:0]  right_words,
    output logic                           bit_out
);

    localparam int WBITS = $clog2(WORD_W);
    localparam int SRC_W = $clog2(NUM_IN);

    logic [OBIT_W-1:0] word_pos;
    chan_e             chan;
    logic [SRC_W-1:0]  src_sel;
    logic [WBITS-1:0]  bit_sel;
    logic [WORD_W-1:0] word;

    always_comb begin
        // One bit clock of delay: position 0 carries the LSB of the last slot.
        word_pos = out_pos - 1'b1;
        chan     = chan_e'(word_pos[OBIT_W-1]);
        src_sel  = word_pos[WBITS +: SRC_W];
        bit_sel  = WBITS'(msb_first_index(WORD_W, int'(word_pos[WBITS-1:0])));
        case (chan)
            CH_LEFT:  word = left_words[src_sel];
            default:  word = right_words[src_sel];
        endcase
        bit_out = word[bit_sel];
    end

endmodule

// File: rtl/i2s_word_merger.sv
// Joins NUM_IN stereo sources into one merged stereo stream, word by word.
module i2s_word_merger #(
    parameter int WORD_W    = 16,
    parameter int NUM_IN    = 2,
    parameter int ODIV_LOG2 = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_IN-1:0] src_sd,
    output logic              src_bclk,
    output logic              src_ws,
    output logic              mrg_bclk,
    output logic              mrg_ws,
    output logic              mrg_sd
);

    localparam int WBITS     = $clog2(WORD_W);
    localparam int SRC_W     = $clog2(NUM_IN);
    localparam int IDIV_LOG2 = ODIV_LOG2 + SRC_W;
    localparam int IBIT_W    = WBITS + 1;
    localparam int OBIT_W    = WBITS + 1 + SRC_W;
    localparam int CNT_W     = ODIV_LOG2 + OBIT_W;

    localparam logic [IBIT_W-1:0] LEFT_DONE  = IBIT_W'(WORD_W);
    localparam logic [IBIT_W-1:0] RIGHT_DONE = '0;

    logic              sample_stb;
    logic [IBIT_W-1:0] in_bit_idx;
    logic [OBIT_W-1:0] nxt_pos;
    logic              nxt_edge;
    logic              nxt_obclk;
    logic              nxt_ws;
    logic              mux_bit;

    logic [NUM_IN-1:0][WORD_W-1:0] left_words;
    logic [NUM_IN-1:0][WORD_W-1:0] right_words;

    i2s_merge_timebase #(
        .ODIV_LOG2 (ODIV_LOG2),
        .IDIV_LOG2 (IDIV_LOG2),
        .IBIT_W    (IBIT_W),
        .OBIT_W    (OBIT_W),
        .CNT_W     (CNT_W)
    ) i_timebase (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_stb (sample_stb),
        .in_bit_idx (in_bit_idx),
        .in_bclk    (src_bclk),
        .in_ws      (src_ws),
        .nxt_pos    (nxt_pos),
        .nxt_edge   (nxt_edge),
        .nxt_obclk  (nxt_obclk),
        .nxt_ws     (nxt_ws)
    );

    for (genvar s = 0; s < NUM_IN; s++) begin : g_src
        i2s_merge_capture #(
            .WORD_W (WORD_W),
            .IBIT_W (IBIT_W)
        ) i_capture (
            .clk        (clk),
            .rst_n      (rst_n),
            .sample_stb (sample_stb),
            .bit_idx    (in_bit_idx),
            .sd         (src_sd[s]),
            .left_word  (left_words[s]),
            .right_word (right_words[s])
        );
    end

    i2s_merge_slot_mux #(
        .WORD_W (WORD_W),
        .NUM_IN (NUM_IN),
        .OBIT_W (OBIT_W)
    ) i_slot_mux (
        .out_pos     (nxt_pos),
        .left_words  (left_words),
        .right_words (right_words),
        .bit_out     (mux_bit)
    );

    typedef struct packed {
        logic left_seen;
        logic live;
        logic obclk;
        logic ows;
        logic osd;
    } top_state_t;

    top_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (sample_stb && in_bit_idx == LEFT_DONE) begin
            st_d.left_seen = 1'b1;
        end
        if (sample_stb && in_bit_idx == RIGHT_DONE && st_q.left_seen) begin
            st_d.live = 1'b1;
        end
        st_d.obclk = st_d.live & nxt_obclk;
        st_d.ows   = st_d.live & nxt_ws;
        if (!st_d.live) begin
            st_d.osd = 1'b0;
        end else if (nxt_edge) begin
            st_d.osd = mux_bit;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mrg_bclk = st_q.obclk;
    assign mrg_ws   = st_q.ows;
    assign mrg_sd   = st_q.osd;

endmodule

// File: rtl/i2s_word_merger_chk.sv
module i2s_word_merger_chk (
    input logic clk,
    input logic rst_n,
    input logic src_bclk,
    input logic src_ws,
    input logic mrg_bclk,
    input logic mrg_ws,
    input logic mrg_sd
);

    logic [1:0] ws_falls_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ws_falls_q <= '0;
        end else if ($fell(src_ws) && ws_falls_q != 2'd3) begin
            ws_falls_q <= ws_falls_q + 2'd1;
        end
    end

    AST_SRC_BCLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(src_bclk) |=> src_bclk); // R2
    AST_SRC_BCLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(src_bclk) |=> !src_bclk); // R2
    AST_SRC_WS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(src_ws) |-> !src_bclk); // R3
    AST_MRG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (ws_falls_q == 2'd0) |-> (!mrg_bclk && !mrg_ws && !mrg_sd)); // R5
    AST_MRG_WS_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        mrg_ws |-> src_ws); // R6
    AST_MRG_BCLK_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mrg_bclk) |=> mrg_bclk ##1 !mrg_bclk); // R6
    AST_MRG_SD_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        mrg_bclk |-> $stable(mrg_sd)); // R7

endmodule

bind i2s_word_merger i2s_word_merger_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_bclk (src_bclk),
    .src_ws   (src_ws),
    .mrg_bclk (mrg_bclk),
    .mrg_ws   (mrg_ws),
    .mrg_sd   (mrg_sd)
);

// File: tb/test_i2s_word_merger.sv
module test_i2s_word_merger;

    localparam int N_SRC   = 2;
    localparam int FRAMES  = 10;
    localparam int WD_LIMIT = 20000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N_SRC-1:0] src_sd = '0;
    logic src_bclk, src_ws, mrg_bclk, mrg_ws, mrg_sd;

    always #4 clk = ~clk;

    i2s_word_merger i_i2s_word_merger (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_sd   (src_sd),
        .src_bclk (src_bclk),
        .src_ws   (src_ws),
        .mrg_bclk (mrg_bclk),
        .mrg_ws   (mrg_ws),
        .mrg_sd   (mrg_sd)
    );

    int checks = 0;
    int errors = 0;
    int k = 0;
    bit running = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) k <= 0;
        else        k <= k + 1;
    end

    function automatic logic [15:0] word_of(int f, int s, int c);
        if (f == 0) return (s == 0) ? ((c == 0) ? 16'h8000 : 16'hFFFF)
                                    : ((c == 0) ? 16'h0001 : 16'h0000);
        if (f == 1) return (s == 0) ? ((c == 0) ? 16'hAAAA : 16'h5555)
                                    : ((c == 0) ? 16'h00FF : 16'hFF00);
        return 16'((f * 40503 + s * 4660 + c * 3855) ^ (f << 5));
    endfunction

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h (k=%0d)", tag, act, exp, k);
        end
    endtask

    // source transmitter state
    int tx_pos = 0, tx_f = 0;
    logic tx_last_ws = 1'b0, tx_last_b = 1'b0;
    // merged receiver state
    int rx_op = 0, rx_f = 0;
    logic rx_last_ws = 1'b0, rx_last_b = 1'b0, prev_sd = 1'b0;
    logic [63:0] rx_frame = '0;

    always @(negedge clk) begin
        if (rst_n && running) begin
            // cycle reference for the clocks and the quiet period
            bit live;
            bit exp_sb, exp_ws;
            live   = (k >= 260);
            exp_sb = ((k % 8) >= 4);
            exp_ws = ((k % 256) >= 128);
            check(src_bclk == exp_sb, "R2 src_bclk", 32'(src_bclk), 32'(exp_sb));
            check(src_ws == exp_ws, "R3 src_ws", 32'(src_ws), 32'(exp_ws));
            if (!live) begin
                check({mrg_bclk, mrg_ws, mrg_sd} == 3'b000, "R5 quiet merged outputs",
                      32'({mrg_bclk, mrg_ws, mrg_sd}), 32'(0));
            end else begin
                check(mrg_bclk == ((k % 4) >= 2), "R6 mrg_bclk", 32'(mrg_bclk),
                      32'((k % 4) >= 2));
                check(mrg_ws == exp_ws, "R6 mrg_ws", 32'(mrg_ws), 32'(exp_ws));
            end
            if (mrg_bclk) begin
                check(mrg_sd == prev_sd, "R7 mrg_sd steady", 32'(mrg_sd), 32'(prev_sd));
            end
            prev_sd = mrg_sd;

            // transmitter: change data after each falling source bit clock
            if (tx_last_b && !src_bclk) begin
                if (src_ws != tx_last_ws) begin
                    tx_pos = 0;
                    if (!src_ws) tx_f++;
                    tx_last_ws = src_ws;
                end else begin
                    tx_pos++;
                end
            end
            tx_last_b = src_bclk;
            for (int s = 0; s < N_SRC; s++) begin
                logic [15:0] w;
                if (tx_pos == 0) begin
                    if (!src_ws) w = (tx_f == 0) ? 16'h0000 : word_of(tx_f - 1, s, 1);
                    else         w = word_of(tx_f, s, 0);
                    src_sd[s] <= w[0];
                end else if (tx_pos <= 16) begin
                    w = word_of(tx_f, s, int'(src_ws));
                    src_sd[s] <= w[16 - tx_pos];
                end else begin
                    src_sd[s] <= 1'b0;
                end
            end

            // receiver: take a bit on each rising merged bit clock
            if (!rx_last_b && mrg_bclk) begin
                int idx;
                if (!mrg_ws && rx_last_ws) rx_op = 0;
                else                       rx_op++;
                rx_last_ws = mrg_ws;
                idx = (rx_op == 0) ? 63 : ((rx_op - 1) % 64);
                rx_frame[63 - idx] = mrg_sd;
                if (rx_op == 0) begin
                    if (rx_f == 0) begin
                        check(k == 514, "R9 first frame end cycle", 32'(k), 32'(514));
                    end
                    for (int slot = 0; slot < 4; slot++) begin
                        logic [15:0] exp_w, act_w;
                        exp_w = word_of(rx_f, slot % 2, slot / 2);
                        act_w = rx_frame[63 - 16 * slot -: 16];
                        check(act_w == exp_w, "R4 R8 R9 slot word", 32'(act_w), 32'(exp_w));
                    end
                    rx_f++;
                end
            end
            rx_last_b = mrg_bclk;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: all outputs low during reset
        check({src_bclk, src_ws, mrg_bclk, mrg_ws, mrg_sd} == 5'b0, "R1 in reset",
              32'({src_bclk, src_ws, mrg_bclk, mrg_ws, mrg_sd}), 32'(0));
        rst_n = 1'b1;
        @(negedge clk);
        check({src_bclk, src_ws, mrg_bclk, mrg_ws, mrg_sd} == 5'b0, "R1 after release",
              32'({src_bclk, src_ws, mrg_bclk, mrg_ws, mrg_sd}), 32'(0));
        running = 1'b1;
        while (rx_f < FRAMES && k < WD_LIMIT) @(negedge clk);
        if (rx_f < FRAMES) begin
            check(1'b0, "R8 watchdog frames received", 32'(rx_f), 32'(FRAMES));
        end
        running = 1'b0;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule